// File: doc/BRIEF.md
# Sensor Soft Reset and Standby Controller

This block sits between the register file of an image sensor and its frame-timing core. It decodes writes to a reset control register at a fixed address and turns each request into a one-shot action.

The logic reset request resets the digital core at once. Serial-interface configuration is left alone, because that lives outside the reset output's reach. One cycle later the block issues a frame-restart pulse, so the frame being produced is abandoned and a fresh one begins. The gain/exposure reset request is held pending and released at the next frame boundary, so that the automatic gain and exposure loop is reset between frames and never part-way through one. Both request bits clear themselves: every accepted write acts exactly once, and nothing remains to be cleared by software.

The same block governs low-power standby from an asynchronous pin. After synchronisation, a standby request during a frame lets that frame finish and only then drops the logic enable, the internal clock enable and the analog power enable. A request outside a frame takes effect on the next cycle. Releasing the pin restores all three enables. A two-bit status output tells the frame core and the register file which phase the block is in.

Top module: `sns_rst_stby_ctrl`

## Requirements
- R1: While reset is held and after it is released with no other stimulus, status_o is 2'b00 (active), all three enables are 1 and the three pulse outputs are 0.
- R2: A write of data with bit 0 set to address 0x0C drives logic_rst_o high for one cycle, in the cycle after the write is sampled.
- R3: frame_restart_o is high for exactly one cycle, in the cycle after logic_rst_o.
- R4: A write with bit 1 set to address 0x0C makes aec_rst_o pulse for one cycle, in the cycle after the first frame_end that follows the write. A write sampled in the same cycle as frame_end waits for the next frame_end.
- R5: Request bits clear themselves. A write acts once: a later frame_end gives no further aec_rst_o, and no output stays asserted. A write to another address, or with bits 1:0 both zero, produces no pulse. Bit 1 alone produces no logic reset.
- R6: stby_pin passes through a two-flop synchronizer. With frame_active low, status_o becomes 2'b10 (standby) and all enables drop at the third rising edge after the pin rises, and not before.
- R7: If frame_active is high when the synchronized request is seen, status_o becomes 2'b01 (draining) with all enables still high. It moves to standby at the edge that samples frame_end.
- R8: When the synchronized pin falls, the block returns to active (2'b00) with enables high. This happens from standby and also from draining, where it cancels the pending standby.
- R9: Writes to the reset register sampled while in standby are ignored: no logic_rst_o, no frame_restart_o, and no gain/exposure request is left pending for after standby.
- R10: status_o only takes the codes 2'b00 active, 2'b01 draining, 2'b10 standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 16 | Register write data |
| frame_active | input | 1 | High while the timing core is producing a frame |
| frame_end | input | 1 | One-cycle pulse at the end of each frame |
| stby_pin | input | 1 | Asynchronous standby request, high requests standby |
| logic_rst_o | output | 1 | One-cycle digital core reset pulse |
| frame_restart_o | output | 1 | One-cycle pulse to start a new frame |
| aec_rst_o | output | 1 | One-cycle gain/exposure loop reset pulse |
| clk_en_o | output | 1 | Internal clock enable |
| logic_en_o | output | 1 | Digital logic enable |
| ana_en_o | output | 1 | Analog power enable |
| status_o | output | 2 | 00 active, 01 draining, 10 standby |

## Verification
The bench writes the gain/exposure request in the same cycle as a frame boundary. A design that let that request through would reset the loop a whole frame early. It also sends a second boundary after the pulse, to catch a pending bit that never clears and fires every frame. Standby is entered both inside and outside a frame, and the enables are sampled one cycle short of the synchronizer delay. A design that powers down mid-frame or skips synchronisation shows its enables dropping too soon. Reset writes sent during standby and a pin released while draining expose designs that act on requests while powered down or that cannot cancel a pending standby.

// File: rtl/sns_rst_pkg.sv
package sns_rst_pkg;

  // Power phase of the controller; the code is also the status output
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'b00,
    ST_DRAIN  = 2'b01,
    ST_STBY   = 2'b10
  } pwr_state_e;

endpackage

// File: rtl/sns_rst_sync.sv
// Reset synchronizer: asserts asynchronously, releases after STAGES edges
module sns_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/sns_bit_sync.sv
// Multi-flop synchronizer for a single level signal
module sns_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], d};
    end
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/sns_rst_req.sv
// Decodes reset-register writes into self-clearing one-shot pulses
module sns_rst_req #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 16,
  parameter logic [7:0]  RST_ADDR  = 8'h0C,
  parameter int          LOGIC_BIT = 0,
  parameter int          AEC_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_end,
  output logic              logic_rst_o,
  output logic              frame_restart_o,
  output logic              aec_rst_o
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(RST_ADDR);

  logic hit;
  logic logic_d, logic_q;
  logic restart_d, restart_q;
  logic aec_d, aec_q;
  logic pend_d, pend_q, pend_en;

  // Next-state logic
  always_comb begin
    hit       = wr_en && (addr == HIT_ADDR) && accept;
    logic_d   = hit && wdata[LOGIC_BIT];
    restart_d = logic_q;
    aec_d     = frame_end && pend_q;
    pend_d    = pend_q;
    if (frame_end && pend_q) begin
      pend_d = 1'b0;
    end
    if (hit && wdata[AEC_BIT]) begin
      pend_d = 1'b1;
    end
    pend_en = (pend_d != pend_q);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      logic_q   <= 1'b0;
      restart_q <= 1'b0;
      aec_q     <= 1'b0;
    end else begin
      logic_q   <= logic_d;
      restart_q <= restart_d;
      aec_q     <= aec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign logic_rst_o     = logic_q;
  assign frame_restart_o = restart_q;
  assign aec_rst_o       = aec_q;

endmodule

// File: rtl/sns_stby_fsm.sv
// Standby sequencer: defers power-down to the end of the running frame
module sns_stby_fsm
  import sns_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_req,
  input  logic       frame_active,
  input  logic       frame_end,
  output pwr_state_e state_o
);

  pwr_state_e state_q, state_d;
  logic       state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: begin
        if (stby_req) begin
          state_d = frame_active ? ST_DRAIN : ST_STBY;
        end
      end
      ST_DRAIN: begin
        if (!stby_req) begin
          state_d = ST_ACTIVE;
        end else if (frame_end) begin
          state_d = ST_STBY;
        end
      end
      ST_STBY: begin
        if (!stby_req) begin
          state_d = ST_ACTIVE;
        end
      end
      default: state_d = ST_ACTIVE;
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/sns_rst_stby_ctrl.sv
// Top: soft reset decoding plus deferred standby control
module sns_rst_stby_ctrl
  import sns_rst_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 16,
  parameter logic [7:0] RST_ADDR    = 8'h0C,
  parameter int         SYNC_STAGES = 2,
  parameter int         RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              frame_active,
  input  logic              frame_end,
  input  logic              stby_pin,
  output logic              logic_rst_o,
  output logic              frame_restart_o,
  output logic              aec_rst_o,
  output logic              clk_en_o,
  output logic              logic_en_o,
  output logic              ana_en_o,
  output logic [1:0]        status_o
);

  logic       rst_core_n;
  logic       stby_s;
  logic       powered;
  pwr_state_e state;

  sns_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_core_n)
  );

  sns_bit_sync #(.STAGES(SYNC_STAGES)) u_stby_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (stby_pin),
    .q     (stby_s)
  );

  sns_stby_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .stby_req     (stby_s),
    .frame_active (frame_active),
    .frame_end    (frame_end),
    .state_o      (state)
  );

  assign powered = (state != ST_STBY);

  sns_rst_req #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RST_ADDR  (RST_ADDR),
    .LOGIC_BIT (0),
    .AEC_BIT   (1)
  ) u_req (
    .clk             (clk),
    .rst_n           (rst_core_n),
    .accept          (powered),
    .wr_en           (reg_wr_en),
    .addr            (reg_addr),
    .wdata           (reg_wdata),
    .frame_end       (frame_end),
    .logic_rst_o     (logic_rst_o),
    .frame_restart_o (frame_restart_o),
    .aec_rst_o       (aec_rst_o)
  );

  assign clk_en_o   = powered;
  assign logic_en_o = powered;
  assign ana_en_o   = powered;
  assign status_o   = state;

endmodule

// File: rtl/sns_rst_stby_chk.sv
// Property checker attached to the top module
module sns_rst_stby_chk #(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 16,
  parameter logic [7:0] RST_ADDR = 8'h0C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              frame_end,
  input logic              logic_rst_o,
  input logic              frame_restart_o,
  input logic              aec_rst_o,
  input logic [1:0]        status_o
);

  localparam logic [ADDR_W-1:0] A = ADDR_W'(RST_ADDR);

  AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst_o |-> $past(reg_wr_en && reg_addr == A && reg_wdata[0])); // R2

  AST_RESTART_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst_o |=> frame_restart_o); // R3

  AST_AEC_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    aec_rst_o |-> $past(frame_end)); // R4

  AST_STBY_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'b10 && $past(status_o) == 2'b01) |-> $past(frame_end)); // R7

  AST_NO_RST_IN_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_o) == 2'b10) |-> !logic_rst_o); // R9

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    status_o != 2'b11); // R10

endmodule

bind sns_rst_stby_ctrl sns_rst_stby_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .RST_ADDR (RST_ADDR)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_core_n),
  .reg_wr_en       (reg_wr_en),
  .reg_addr        (reg_addr),
  .reg_wdata       (reg_wdata),
  .frame_end       (frame_end),
  .logic_rst_o     (logic_rst_o),
  .frame_restart_o (frame_restart_o),
  .aec_rst_o       (aec_rst_o),
  .status_o        (status_o)
);

// File: tb/sns_rst_stby_ctrl_bench.sv
`timescale 1ns/1ps
module sns_rst_stby_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        frame_active;
  logic        frame_end;
  logic        stby_pin;
  logic        logic_rst_o, frame_restart_o, aec_rst_o;
  logic        clk_en_o, logic_en_o, ana_en_o;
  logic [1:0]  status_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  sns_rst_stby_ctrl u_sns_rst_stby_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_wr_en       (reg_wr_en),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .frame_active    (frame_active),
    .frame_end       (frame_end),
    .stby_pin        (stby_pin),
    .logic_rst_o     (logic_rst_o),
    .frame_restart_o (frame_restart_o),
    .aec_rst_o       (aec_rst_o),
    .clk_en_o        (clk_en_o),
    .logic_en_o      (logic_en_o),
    .ana_en_o        (ana_en_o),
    .status_o        (status_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] outs();
    return {26'd0, status_o, clk_en_o, logic_en_o, ana_en_o, logic_rst_o | frame_restart_o | aec_rst_o};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic fe);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d; frame_end = fe;
    cyc(1);
    reg_wr_en = 1'b0; frame_end = 1'b0;
  endtask

  task automatic pulse_fe();
    frame_end = 1'b1;
    cyc(1);
    frame_end = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status during reset", {30'd0, status_o}, 32'h0);
    chk("R1 pulses during reset", {29'd0, logic_rst_o, frame_restart_o, aec_rst_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    cyc(3);
    chk("R1 state after release", outs(), {26'd0, 2'b00, 3'b111, 1'b0});
  endtask

  task automatic t_logic_rst();
    wr(8'h0C, 16'h0001, 1'b0);
    chk("R2 logic reset pulse", {31'd0, logic_rst_o}, 32'd1);
    chk("R3 no restart yet", {31'd0, frame_restart_o}, 32'd0);
    cyc(1);
    chk("R2 logic reset one cycle", {31'd0, logic_rst_o}, 32'd0);
    chk("R3 restart after reset", {31'd0, frame_restart_o}, 32'd1);
    cyc(1);
    chk("R3 restart one cycle", {31'd0, frame_restart_o}, 32'd0);
    cyc(3);
    chk("R5 no repeat after self clear", {30'd0, logic_rst_o, frame_restart_o}, 32'd0);
  endtask

  task automatic t_other_writes();
    wr(8'h0D, 16'h0003, 1'b0);
    chk("R5 other address no pulse", {30'd0, logic_rst_o, aec_rst_o}, 32'd0);
    cyc(1);
    chk("R5 other address no restart", {31'd0, frame_restart_o}, 32'd0);
    wr(8'h0C, 16'hFFFC, 1'b0);
    chk("R5 zero low bits no pulse", {31'd0, logic_rst_o}, 32'd0);
    pulse_fe();
    chk("R5 zero low bits no aec", {31'd0, aec_rst_o}, 32'd0);
  endtask

  task automatic t_aec();
    wr(8'h0C, 16'h0002, 1'b0);
    chk("R5 bit1 no logic reset", {31'd0, logic_rst_o}, 32'd0);
    chk("R4 aec waits for boundary", {31'd0, aec_rst_o}, 32'd0);
    cyc(4);
    chk("R4 aec still waiting", {31'd0, aec_rst_o}, 32'd0);
    pulse_fe();
    chk("R4 aec at boundary", {31'd0, aec_rst_o}, 32'd1);
    cyc(1);
    chk("R4 aec one cycle", {31'd0, aec_rst_o}, 32'd0);
    pulse_fe();
    chk("R5 aec cleared after use", {31'd0, aec_rst_o}, 32'd0);
  endtask

  task automatic t_aec_same_cycle();
    wr(8'h0C, 16'h0002, 1'b1);
    chk("R4 same-cycle write not applied", {31'd0, aec_rst_o}, 32'd0);
    cyc(2);
    pulse_fe();
    chk("R4 same-cycle write at next boundary", {31'd0, aec_rst_o}, 32'd1);
    cyc(1);
  endtask

  task automatic t_stby_idle();
    frame_active = 1'b0;
    stby_pin = 1'b1;
    cyc(2);
    chk("R6 not before sync delay", outs(), {26'd0, 2'b00, 3'b111, 1'b0});
    cyc(1);
    chk("R6 standby idle", outs(), {26'd0, 2'b10, 3'b000, 1'b0});
    stby_pin = 1'b0;
    cyc(3);
    chk("R8 exit standby", outs(), {26'd0, 2'b00, 3'b111, 1'b0});
  endtask

  task automatic t_stby_drain();
    frame_active = 1'b1;
    stby_pin = 1'b1;
    cyc(3);
    chk("R7 draining keeps enables", outs(), {26'd0, 2'b01, 3'b111, 1'b0});
    cyc(5);
    chk("R7 still draining", outs(), {26'd0, 2'b01, 3'b111, 1'b0});
    pulse_fe();
    frame_active = 1'b0;
    chk("R7 standby after frame end", outs(), {26'd0, 2'b10, 3'b000, 1'b0});
    stby_pin = 1'b0;
    cyc(3);
    chk("R8 exit after drain", outs(), {26'd0, 2'b00, 3'b111, 1'b0});
  endtask

  task automatic t_stby_cancel();
    frame_active = 1'b1;
    stby_pin = 1'b1;
    cyc(3);
    chk("R8 draining before cancel", {30'd0, status_o}, 32'h1);
    stby_pin = 1'b0;
    cyc(3);
    chk("R8 cancel from draining", outs(), {26'd0, 2'b00, 3'b111, 1'b0});
    pulse_fe();
    chk("R8 stays active after cancel", {30'd0, status_o}, 32'h0);
    frame_active = 1'b0;
  endtask

  task automatic t_stby_ignore();
    stby_pin = 1'b1;
    cyc(3);
    chk("R9 in standby", {30'd0, status_o}, 32'h2);
    wr(8'h0C, 16'h0003, 1'b0);
    chk("R9 no logic reset in standby", {31'd0, logic_rst_o}, 32'd0);
    cyc(1);
    chk("R9 no restart in standby", {31'd0, frame_restart_o}, 32'd0);
    stby_pin = 1'b0;
    cyc(3);
    chk("R9 back active", {30'd0, status_o}, 32'h0);
    pulse_fe();
    chk("R9 no aec left pending", {31'd0, aec_rst_o}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    frame_active = 1'b0; frame_end = 1'b0; stby_pin = 1'b0;
    cyc(4);
    t_reset();
    t_logic_rst();
    t_other_writes();
    t_aec();
    t_aec_same_cycle();
    t_stby_idle();
    t_stby_drain();
    t_stby_cancel();
    t_stby_ignore();
    chk("R10 final status legal", {31'd0, status_o == 2'b11}, 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule